// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block drives one timer channel onto a pair of complementary output legs, a positive leg and a negative leg. A reference waveform from the compare logic comes in. Each leg leaves the block as two signals: a drive enable and a level. An undriven leg (high impedance) is therefore distinct from a leg that is driven low. The block decides whether each leg is driven, and at which level, from a stored arm bit, two off-state drive selects, per-leg enables, polarities and idle levels.

When both legs are enabled, the block inserts a programmable dead time, counted in clock cycles, before either leg becomes active. A fault input forces the legs combinationally to their inactive levels. The fault also clears the arm bit on the next edge. After one dead time the legs settle to their idle levels. The arm bit stays cleared until it is set again, so a fault is sticky. The leg enables can be held in a preload stage and moved into effect only on a commutation strobe. This lets both legs of several channels change together.

Top module: `cpwm_outstage`

## Requirements
- R1: A leg carrying the waveform is driven at (active XOR polarity). A leg in the off state is driven at its polarity bit, which is its inactive level. A leg that is not driven has drive=0 and level=0.
- R2: While armed with neither leg enable in effect, both legs are undriven if run_offdrv=0. Both legs are driven at their inactive levels if run_offdrv=1.
- R3: While armed with exactly one leg enable in effect, that leg is active while the registered reference is 1, with no dead time. Its output changes on the first edge after the reference changes. The other leg is undriven if run_offdrv=0, and off if run_offdrv=1.
- R4: While armed with both enables in effect, the positive leg is active when the registered reference is 1 and the negative leg is active when it is 0. When the reference sampled at edge k differs from the previous sample, the leg going inactive changes after edge k. The leg going active changes after edge k+dead_cycles.
- R5: While armed and with both legs driven, the two legs are never active at the same time.
- R6: While not armed, both legs are undriven if idle_offdrv=0. If idle_offdrv=1, both legs are driven: at their inactive levels for dead_cycles edges after the arm bit drops, and then at pos_idle and neg_idle.
- R7: brk_a=1 takes the legs into the not-armed behaviour of R6 at once, without waiting for a clock edge. The arm bit is 0 after the next edge.
- R8: The arm bit rises only at an edge where arm_set=1, arm_clr=0 and no fault is active. Otherwise it keeps its value until arm_clr or a fault clears it.
- R9: With comm_preload=1, the requested enables are copied into effect only at an edge where comm_strobe=1. With comm_preload=0, they are copied at every edge.
- R10: brk_b acts as a fault only while run_offdrv=1 and idle_offdrv=1. Otherwise it has no effect.
- R11: In complementary mode, a reference pulse that lasts fewer cycles than dead_cycles never makes the leg that would go active become active.
- R12: After reset the arm bit and the enables in effect are 0, and both dead-time counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference waveform from the compare logic |
| arm_set | input | 1 | Set the arm bit (main output enable) |
| arm_clr | input | 1 | Clear the arm bit; wins over arm_set |
| run_offdrv | input | 1 | Drive disabled legs at inactive level while armed |
| idle_offdrv | input | 1 | Drive legs while not armed |
| pos_en_req | input | 1 | Requested positive-leg enable |
| neg_en_req | input | 1 | Requested negative-leg enable |
| comm_preload | input | 1 | Hold enable requests until a commutation strobe |
| comm_strobe | input | 1 | Commutation event |
| pos_pol | input | 1 | Positive-leg polarity (inactive level) |
| neg_pol | input | 1 | Negative-leg polarity (inactive level) |
| pos_idle | input | 1 | Positive-leg idle level |
| neg_idle | input | 1 | Negative-leg idle level |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| brk_a | input | 1 | Primary fault input, asynchronous effect |
| brk_b | input | 1 | Secondary fault input, gated by both off-state selects |
| pos_out | output | 1 | Positive-leg level |
| pos_drv | output | 1 | Positive-leg drive enable |
| neg_out | output | 1 | Negative-leg level |
| neg_drv | output | 1 | Negative-leg drive enable |
| armed | output | 1 | Current arm bit |

## Verification
Properties checked on every cycle:
- While armed with both legs driven, the two legs are never active together.
- An undriven leg always shows level 0.
- A fault always clears the arm bit on the next edge.
- The arm bit never rises without a set request.
- With preload active, the enables in effect stay unchanged until a strobe.
- Not armed with idle_offdrv=0 (including an active primary fault) always means both legs are undriven.

Only the bench scenarios can show the following:
- The exact cycle on which a leg goes active after the dead time.
- Suppression of pulses shorter than the dead time.
- The transition from inactive to idle levels after a fault.
- The gating of the secondary fault.
- The full mapping of enables, selects and polarities to levels.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   typedef enum logic [1:0] {
      LEG_HIZ  = 2'd0,
      LEG_OFF  = 2'd1,
      LEG_WAVE = 2'd2,
      LEG_IDLE = 2'd3
   } leg_mode_e;

   typedef struct packed {
      logic drive;
      logic level;
   } pin_t;

   // Turn a leg mode into a pin: waveform is active XOR polarity,
   // off is the polarity bit, idle is the given idle level.
   function automatic pin_t leg_pin(leg_mode_e mode, logic act, logic pol, logic idl);
      pin_t p;
      case (mode)
         LEG_WAVE: begin p.drive = 1'b1; p.level = act ^ pol; end
         LEG_OFF:  begin p.drive = 1'b1; p.level = pol;       end
         LEG_IDLE: begin p.drive = 1'b1; p.level = idl;       end
         default:  begin p.drive = 1'b0; p.level = 1'b0;      end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_in,
   input  logic [DT_W-1:0] dead_cycles,
   output logic            ref_q,
   output logic            pos_gate,
   output logic            neg_gate
);

   logic [DT_W-1:0] gap_cnt;
   logic            quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= 1'b0;
         gap_cnt <= '0;
      end else begin
         ref_q <= ref_in;
         if (ref_in != ref_q)
            gap_cnt <= dead_cycles;
         else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - 1'b1;
      end
   end

   assign quiet    = (gap_cnt == '0);
   assign pos_gate = ref_q & quiet;
   assign neg_gate = ~ref_q & quiet;

endmodule

// File: rtl/cpwm_en_shadow.sv
module cpwm_en_shadow #(
   parameter int N_EN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_EN-1:0] en_req,
   input  logic            preload,
   input  logic            strobe,
   output logic [N_EN-1:0] en_live
);

   logic take;
   assign take = ~preload | strobe;

   for (genvar i = 0; i < N_EN; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_live[i] <= 1'b0;
         else if (take)
            en_live[i] <= en_req[i];
      end
   end

endmodule

// File: rtl/cpwm_fault_ctl.sv
module cpwm_fault_ctl #(
   parameter int DT_W    = 8,
   parameter bit BRK2_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm_set,
   input  logic            arm_clr,
   input  logic            brk_a,
   input  logic            brk_b,
   input  logic            run_offdrv,
   input  logic            idle_offdrv,
   input  logic [DT_W-1:0] dead_cycles,
   output logic            armed,
   output logic            run_live,
   output logic            settled
);

   logic            trip;
   logic [DT_W-1:0] idle_cnt;

   if (BRK2_EN) begin : g_two_faults
      assign trip = brk_a | (brk_b & run_offdrv & idle_offdrv);
   end else begin : g_one_fault
      logic unused_b;
      assign unused_b = brk_b;
      assign trip     = brk_a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (trip || arm_clr)
         armed <= 1'b0;
      else if (arm_set)
         armed <= 1'b1;
   end

   assign run_live = armed & ~trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_cnt <= '0;
      else if (run_live)
         idle_cnt <= dead_cycles;
      else if (idle_cnt != '0)
         idle_cnt <= idle_cnt - 1'b1;
   end

   assign settled = (idle_cnt == '0);

endmodule

// File: rtl/cpwm_outdecode.sv
module cpwm_outdecode
   import cpwm_pkg::*;
(
   input  logic       run_live,
   input  logic       run_offdrv,
   input  logic       idle_offdrv,
   input  logic       settled,
   input  logic [1:0] en_live,
   input  logic       ref_q,
   input  logic       pos_gate,
   input  logic       neg_gate,
   input  logic       pos_pol,
   input  logic       neg_pol,
   input  logic       pos_idle,
   input  logic       neg_idle,
   output pin_t       pos_pin,
   output pin_t       neg_pin
);

   leg_mode_e pos_mode, neg_mode;
   logic      pos_act, neg_act;
   leg_mode_e spare_mode;

   always_comb begin
      spare_mode = run_offdrv ? LEG_OFF : LEG_HIZ;
      pos_act    = 1'b0;
      neg_act    = 1'b0;
      if (run_live) begin
         case (en_live)
            2'b11: begin
               pos_mode = LEG_WAVE; pos_act = pos_gate;
               neg_mode = LEG_WAVE; neg_act = neg_gate;
            end
            2'b01: begin
               pos_mode = LEG_WAVE; pos_act = ref_q;
               neg_mode = spare_mode;
            end
            2'b10: begin
               pos_mode = spare_mode;
               neg_mode = LEG_WAVE; neg_act = ref_q;
            end
            default: begin
               pos_mode = spare_mode;
               neg_mode = spare_mode;
            end
         endcase
      end else if (idle_offdrv) begin
         pos_mode = settled ? LEG_IDLE : LEG_OFF;
         neg_mode = settled ? LEG_IDLE : LEG_OFF;
      end else begin
         pos_mode = LEG_HIZ;
         neg_mode = LEG_HIZ;
      end
      pos_pin = leg_pin(pos_mode, pos_act, pos_pol, pos_idle);
      neg_pin = leg_pin(neg_mode, neg_act, neg_pol, neg_idle);
   end

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage
   import cpwm_pkg::*;
#(
   parameter int DT_W    = 8,
   parameter bit BRK2_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_in,
   input  logic            arm_set,
   input  logic            arm_clr,
   input  logic            run_offdrv,
   input  logic            idle_offdrv,
   input  logic            pos_en_req,
   input  logic            neg_en_req,
   input  logic            comm_preload,
   input  logic            comm_strobe,
   input  logic            pos_pol,
   input  logic            neg_pol,
   input  logic            pos_idle,
   input  logic            neg_idle,
   input  logic [DT_W-1:0] dead_cycles,
   input  logic            brk_a,
   input  logic            brk_b,
   output logic            pos_out,
   output logic            pos_drv,
   output logic            neg_out,
   output logic            neg_drv,
   output logic            armed
);

   localparam int N_EN = 2;

   if (DT_W < 1 || DT_W > 16) begin : g_bad_dt_w
      $error("cpwm_outstage: DT_W must lie in 1..16");
   end

   logic [N_EN-1:0] en_live;
   logic            ref_q, pos_gate, neg_gate;
   logic            run_live, settled;
   pin_t            pos_pin, neg_pin;

   cpwm_deadtime #(.DT_W(DT_W)) u_dt (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dead_cycles(dead_cycles),
      .ref_q(ref_q), .pos_gate(pos_gate), .neg_gate(neg_gate)
   );

   cpwm_en_shadow #(.N_EN(N_EN)) u_shadow (
      .clk(clk), .rst_n(rst_n), .en_req({neg_en_req, pos_en_req}),
      .preload(comm_preload), .strobe(comm_strobe), .en_live(en_live)
   );

   cpwm_fault_ctl #(.DT_W(DT_W), .BRK2_EN(BRK2_EN)) u_fault (
      .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
      .brk_a(brk_a), .brk_b(brk_b), .run_offdrv(run_offdrv),
      .idle_offdrv(idle_offdrv), .dead_cycles(dead_cycles),
      .armed(armed), .run_live(run_live), .settled(settled)
   );

   cpwm_outdecode u_dec (
      .run_live(run_live), .run_offdrv(run_offdrv), .idle_offdrv(idle_offdrv),
      .settled(settled), .en_live(en_live), .ref_q(ref_q),
      .pos_gate(pos_gate), .neg_gate(neg_gate),
      .pos_pol(pos_pol), .neg_pol(neg_pol),
      .pos_idle(pos_idle), .neg_idle(neg_idle),
      .pos_pin(pos_pin), .neg_pin(neg_pin)
   );

   assign pos_out = pos_pin.level;
   assign pos_drv = pos_pin.drive;
   assign neg_out = neg_pin.level;
   assign neg_drv = neg_pin.drive;

endmodule

// File: rtl/cpwm_outstage_chk.sv
module cpwm_outstage_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       armed,
   input logic       arm_set,
   input logic       brk_a,
   input logic       idle_offdrv,
   input logic       comm_preload,
   input logic       comm_strobe,
   input logic       pos_out,
   input logic       pos_drv,
   input logic       neg_out,
   input logic       neg_drv,
   input logic       pos_pol,
   input logic       neg_pol,
   input logic [1:0] en_live
);

   // R5
   a_r5_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pos_drv && neg_drv) |-> !((pos_out ^ pos_pol) && (neg_out ^ neg_pol)));

   // R1
   a_r1_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!pos_drv |-> !pos_out) and (!neg_drv |-> !neg_out));

   // R7
   a_r7_fault_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      brk_a |=> !armed);

   // R6
   a_r6_idle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      ((!armed || brk_a) && !idle_offdrv) |-> (!pos_drv && !neg_drv));

   // R8
   a_r8_sticky_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !arm_set) |=> !armed);

   // R9
   a_r9_preload_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (comm_preload && !comm_strobe) |=> $stable(en_live));

endmodule

bind cpwm_outstage cpwm_outstage_chk u_chk (
   .clk(clk), .rst_n(rst_n), .armed(armed), .arm_set(arm_set), .brk_a(brk_a),
   .idle_offdrv(idle_offdrv), .comm_preload(comm_preload), .comm_strobe(comm_strobe),
   .pos_out(pos_out), .pos_drv(pos_drv), .neg_out(neg_out), .neg_drv(neg_drv),
   .pos_pol(pos_pol), .neg_pol(neg_pol), .en_live(en_live)
);

// File: tb/cpwm_outstage_bench.sv
`timescale 1ns/1ps
module cpwm_outstage_bench;

   localparam int DT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_in = 0, arm_set = 0, arm_clr = 0, run_offdrv = 0, idle_offdrv = 0;
   logic pos_en_req = 0, neg_en_req = 0, comm_preload = 0, comm_strobe = 0;
   logic pos_pol = 0, neg_pol = 0, pos_idle = 0, neg_idle = 0;
   logic [DT_W-1:0] dead_cycles = '0;
   logic brk_a = 0, brk_b = 0;
   logic pos_out, pos_drv, neg_out, neg_drv, armed;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   cpwm_outstage #(.DT_W(DT_W)) u_cpwm_outstage (.*);

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {pdrv,pout,ndrv,nout}/value actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] pins();
      return {pos_drv, pos_out, neg_drv, neg_out};
   endfunction

   // Settled armed model: {pdrv,pout,ndrv,nout}
   function automatic logic [3:0] run_model(logic rd, logic ep, logic en,
                                            logic pp, logic np, logic r);
      logic [1:0] off_p, off_n;
      off_p = rd ? {1'b1, pp} : 2'b00;
      off_n = rd ? {1'b1, np} : 2'b00;
      if (ep && en)       return {1'b1, r ^ pp, 1'b1, ~r ^ np};
      else if (ep)        return {1'b1, r ^ pp, off_n};
      else if (en)        return {off_p, 1'b1, r ^ np};
      else                return {off_p, off_n};
   endfunction

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      check("R12 reset idle undriven", {pins(), 1'b0} >> 1, 4'b0000);
      check("R12 reset disarmed", {3'b0, armed}, 4'b0000);
      rst_n = 1'b1;
      tick(2);

      // R6 idle sweep while disarmed
      dead_cycles = 8'd2;
      for (int i = 0; i < 16; i++) begin
         {idle_offdrv, pos_idle, neg_idle, pos_pol} = i[3:0];
         tick(4);
         check("R6 idle sweep", pins(),
               idle_offdrv ? {1'b1, pos_idle, 1'b1, neg_idle} : 4'b0000);
      end
      idle_offdrv = 0;

      // arming, R8
      arm_set = 1; tick(1); arm_set = 0;
      check("R8 arm set", {3'b0, armed}, 4'b0001);

      // R1 R2 R3 R4 static sweep
      for (int i = 0; i < 64; i++) begin
         {run_offdrv, pos_en_req, neg_en_req, pos_pol, neg_pol, ref_in} = i[5:0];
         tick(5);
         check("R1/R2/R3/R4 run sweep", pins(),
               run_model(run_offdrv, pos_en_req, neg_en_req, pos_pol, neg_pol, ref_in));
      end

      // R4 dead-time timing, D=3
      {run_offdrv, pos_pol, neg_pol, ref_in} = 4'b0000;
      pos_en_req = 1; neg_en_req = 1; dead_cycles = 8'd3;
      tick(6);
      ref_in = 1;
      tick(1);
      check("R4 rise: both inactive after edge k", pins(), 4'b1010);
      tick(2);
      check("R4 rise: pos still held at k+2", pins(), 4'b1010);
      tick(1);
      check("R4 rise: pos active at k+3", pins(), 4'b1110);
      ref_in = 0;
      tick(1);
      check("R4 fall: pos inactive at once", pins(), 4'b1010);
      tick(3);
      check("R4 fall: neg active at k+3", pins(), 4'b1011);

      // R11 short pulse suppressed
      ref_in = 1;
      tick(2);
      ref_in = 0;
      for (int k = 0; k < 6; k++) begin
         if (k == 0) tick(0); else tick(1);
         check("R11 short pulse pos never active", {3'b0, pos_out}, 4'b0000);
      end

      // R4 zero dead time
      dead_cycles = 8'd0;
      tick(3);
      ref_in = 1;
      tick(1);
      check("R4 zero dead time", pins(), 4'b1110);
      ref_in = 0;
      tick(3);

      // R3 single enable ignores dead time
      dead_cycles = 8'd3; neg_en_req = 0; run_offdrv = 1;
      tick(5);
      ref_in = 1;
      tick(1);
      check("R3 single leg no dead time", pins(), 4'b1110);
      ref_in = 0;
      tick(1);
      check("R3 single leg falls next edge", pins(), 4'b1010);

      // R9 preload
      run_offdrv = 0; pos_en_req = 1; neg_en_req = 1;
      tick(5);
      comm_preload = 1; neg_en_req = 0;
      tick(3);
      check("R9 request held without strobe", {2'b0, neg_drv, 1'b0}, 4'b0010);
      comm_strobe = 1; tick(1); comm_strobe = 0;
      check("R9 strobe applies request", {2'b0, neg_drv, 1'b0}, 4'b0000);
      comm_preload = 0; neg_en_req = 1;
      tick(1);
      check("R9 direct write applies next edge", {2'b0, neg_drv, 1'b0}, 4'b0010);

      // R7 fault with idle drive, D=2
      dead_cycles = 8'd2; idle_offdrv = 1; pos_idle = 0; neg_idle = 1;
      ref_in = 1;
      tick(5);
      check("R7 pre-fault waveform", pins(), 4'b1110);
      brk_a = 1; #1;
      check("R7 fault forces inactive at once", pins(), 4'b1010);
      tick(1);
      check("R7 disarmed after edge", {3'b0, armed}, 4'b0000);
      check("R6 inactive during dead time", pins(), 4'b1010);
      tick(1);
      check("R6 idle levels after dead time", pins(), 4'b1011);
      arm_set = 1; tick(1);
      check("R8 set ignored during fault", {3'b0, armed}, 4'b0000);
      arm_set = 0; brk_a = 0; tick(3);
      check("R8 stays disarmed after fault", {3'b0, armed}, 4'b0000);
      arm_set = 1; tick(1); arm_set = 0;
      check("R8 rearm", {3'b0, armed}, 4'b0001);

      // R7 fault without idle drive
      idle_offdrv = 0; tick(2);
      brk_a = 1; #1;
      check("R7 fault undriven when idle select off", pins(), 4'b0000);
      tick(1); brk_a = 0;
      arm_set = 1; tick(1); arm_set = 0;

      // R10 secondary fault gating
      run_offdrv = 0; idle_offdrv = 1; brk_b = 1;
      tick(3);
      check("R10 brk_b ignored run select off", {pins()[3:2], 1'b0, armed}, 4'b1101);
      run_offdrv = 1;
      tick(1);
      check("R10 brk_b trips with both selects", {3'b0, armed}, 4'b0000);
      brk_b = 0;
      arm_clr = 1; arm_set = 1; tick(1); arm_clr = 0; arm_set = 0;
      check("R8 clear wins over set", {3'b0, armed}, 4'b0000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule